// File: doc/BRIEF.md
# EEE Low-Power-Idle Transmit Controller

This block decides when the transmit side of an Ethernet MAC enters and leaves Energy Efficient Ethernet low-power idle. It takes control bits from a configuration register: LPI enable, automatic entry, and a software-written PHY link-good bit. It also takes a timer word holding the link-settle time and the wake time, a transmit-queue-empty flag and a 1 MHz tick. From these it drives an LPI request toward the PHY and a transmit-hold signal toward the transmit datapath.

Entry is only allowed once the link-good bit has stayed high for the settle time, counted in milliseconds. The milliseconds come from groups of 1 MHz ticks. After an exit, the transmitter stays held for the wake time, counted in microsecond ticks.

Transmit entry and exit events are latched as sticky status bits. So are receive-side entry and exit events, which arrive as input pulses. A status read clears all four bits. An interrupt line is high while any of them is set.

Top module: `lpi_tx_ctrl`

## Requirements
- R1: After reset, lpi_req, tx_hold, stat and lpi_irq are all 0.
- R2: lpi_req and tx_hold rise on the clock edge that samples lpi_en, auto_en, the settle condition and txq_empty all high.
- R3: The settle condition is met once link_ok has been sampled high on LS×US_PER_MS consecutive tick cycles. LS is cfg_timer[26:16], in milliseconds, and US_PER_MS defaults to 1000.
- R4: A cycle with link_ok low restarts the settle timing from zero.
- R5: While in LPI, txq_empty low or lpi_en low makes lpi_req fall on the next edge, while tx_hold stays high.
- R6: After an exit, tx_hold falls on the edge that samples the TW-th tick counted after the exit. TW is cfg_timer[15:0], in microseconds. With TW=0 it falls one cycle after the exit, and cycles without a tick do not advance the wait.
- R7: The status bits are stat[0] for transmit entered, stat[1] for transmit exited, stat[2] for receive entered (rx_lpi_enter) and stat[3] for receive exited (rx_lpi_exit). Each is set by its event and stays set.
- R8: A cycle with stat_rd high clears all status bits on the next edge, except a bit whose event occurs in that same cycle, which stays set.
- R9: lpi_irq is high exactly when any status bit is set.
- R10: With auto_en low, LPI is never entered, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpi_en | input | 1 | LPI enable control bit |
| auto_en | input | 1 | Automatic entry on idle transmitter |
| link_ok | input | 1 | Software-written PHY link-good bit |
| cfg_timer | input | 32 | TW in [15:0] (us), LS in [26:16] (ms) |
| txq_empty | input | 1 | Transmit queue empty |
| tick_us | input | 1 | 1 MHz tick, one cycle wide |
| rx_lpi_enter | input | 1 | Receive path entered LPI (pulse) |
| rx_lpi_exit | input | 1 | Receive path left LPI (pulse) |
| stat_rd | input | 1 | Status register read strobe |
| lpi_req | output | 1 | Request LPI signalling toward PHY |
| tx_hold | output | 1 | Block normal transmission |
| stat | output | 4 | Sticky entry/exit status bits |
| lpi_irq | output | 1 | LPI interrupt source |

## Verification
Every output comes from a register one edge away from its cause, so each result can be timed exactly.

- lpi_req, tx_hold and the transmit status bits change on the edge that samples the entry or exit condition.
- The settle condition becomes true right after the edge that counts the last tick. Entry therefore follows one edge later, at edge LS×1000+1 after link_ok rises.
- tx_hold falls on the edge carrying the TW-th tick.
- Status clears and sets appear one edge after the read or event.

The bench changes inputs one time unit after a rising edge and samples one time unit after a later edge. It counts edges from the stimulus to match these offsets, checking both the last cycle before each change and the first cycle after it.

// File: rtl/lpi_pkg.sv
// Shared types for the LPI transmit controller.
package lpi_pkg;
    // Transmit-side LPI state
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LPI    = 2'd1,
        ST_WAKE   = 2'd2
    } lpi_state_t;

    // Status bit positions (software decodes these)
    localparam int ST_TX_ENTER = 0;
    localparam int ST_TX_EXIT  = 1;
    localparam int ST_RX_ENTER = 2;
    localparam int ST_RX_EXIT  = 3;
    localparam int N_STAT      = 4;
endpackage

// File: rtl/lpi_ls_qual.sv
// Link-settle qualifier: counts microsecond ticks into milliseconds while the
// link-good bit is high, restarting on any low cycle, and flags when the
// programmed settle time has elapsed.
// Assumes tick is a single-cycle pulse; the millisecond count saturates.
module lpi_ls_qual #(
    parameter int LS_W      = 11,
    parameter int US_PER_MS = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_ok,
    input  logic            tick,
    input  logic [LS_W-1:0] ls_ms,
    output logic            ls_ok
);
    localparam int US_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
    localparam logic [US_W-1:0] US_LAST = US_W'(US_PER_MS - 1);
    localparam logic [LS_W-1:0] MS_MAX  = '1;

    logic [US_W-1:0] us_cnt;
    logic [LS_W-1:0] ms_cnt;

    // Count ticks and milliseconds while the link bit stays good
    always_ff @(posedge clk) begin
        if (!rst_n || !link_ok) begin
            us_cnt <= '0;
            ms_cnt <= '0;
        end else if (tick) begin
            if (us_cnt == US_LAST) begin
                us_cnt <= '0;
                if (ms_cnt != MS_MAX) ms_cnt <= ms_cnt + 1'b1;
            end else begin
                us_cnt <= us_cnt + 1'b1;
            end
        end
    end

    // Settle condition: link still good and elapsed time reached
    always_comb ls_ok = link_ok && (ms_cnt >= ls_ms);

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok |=> (ms_cnt == '0 && us_cnt == '0));

    // R3
    ms_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok |=> (ms_cnt == $past(ms_cnt) || ms_cnt == $past(ms_cnt) + 1'b1 || ms_cnt == '0));
endmodule

// File: rtl/lpi_tx_fsm.sv
// Transmit LPI sequencer: enters LPI when allowed and the queue is idle,
// leaves on traffic or disable, then holds transmission for the wake time.
// Assumes tick is a single-cycle pulse; outputs are decoded from state.
module lpi_tx_fsm #(
    parameter int TW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lpi_en,
    input  logic            auto_en,
    input  logic            ls_ok,
    input  logic            txq_empty,
    input  logic            tick,
    input  logic [TW_W-1:0] tw_us,
    output logic            lpi_req,
    output logic            tx_hold,
    output logic            ev_enter,
    output logic            ev_exit
);
    import lpi_pkg::*;

    lpi_state_t      state, state_nx;
    logic [TW_W-1:0] tw_cnt;
    logic            go_lpi, leave_lpi;

    // Transition conditions and event pulses
    always_comb begin
        go_lpi    = lpi_en && auto_en && ls_ok && txq_empty;
        leave_lpi = !txq_empty || !lpi_en;
        ev_enter  = (state == ST_ACTIVE) && go_lpi;
        ev_exit   = (state == ST_LPI) && leave_lpi;
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACTIVE: if (go_lpi) state_nx = ST_LPI;
            ST_LPI:    if (leave_lpi) state_nx = ST_WAKE;
            ST_WAKE: begin
                if (tw_cnt == '0) state_nx = ST_ACTIVE;
                else if (tick && tw_cnt == TW_W'(1)) state_nx = ST_ACTIVE;
            end
            default:   state_nx = ST_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= state_nx;
    end

    // Wake-time counter: loaded on exit, counts ticks down in WAKE
    always_ff @(posedge clk) begin
        if (!rst_n)                          tw_cnt <= '0;
        else if (ev_exit)                    tw_cnt <= tw_us;
        else if (state == ST_WAKE && tick && tw_cnt != '0)
                                             tw_cnt <= tw_cnt - 1'b1;
    end

    // Outputs decoded from state
    always_comb begin
        lpi_req = (state == ST_LPI);
        tx_hold = (state != ST_ACTIVE);
    end

    // R2
    entry_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_req) |-> $past(lpi_en && auto_en && ls_ok && txq_empty));

    // R10
    no_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !lpi_req) |=> !lpi_req);

    // R5
    exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_req && (!txq_empty || !lpi_en)) |=> (!lpi_req && tx_hold));

    // R6
    hold_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpi_req) |-> tx_hold);

    // R6
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold && !lpi_req && !tick && tw_cnt > TW_W'(1)) |=> tx_hold);
endmodule

// File: rtl/lpi_status.sv
// Sticky status bits for LPI entry/exit on both paths, cleared by a read,
// plus the interrupt source. An event in a read cycle survives the clear.
module lpi_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         rd,
    output logic [N-1:0] stat,
    output logic         irq
);
    // Per-bit set-dominant sticky flag
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)     stat[i] <= 1'b0;
            else if (ev[i]) stat[i] <= 1'b1;
            else if (rd)    stat[i] <= 1'b0;
        end
    end

    // Interrupt source is the OR of all flags
    always_comb irq = |stat;

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ev == '0) |=> (stat == '0));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((stat & $past(stat)) == $past(stat)));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((stat & $past(ev)) == $past(ev)));
endmodule

// File: rtl/lpi_tx_ctrl.sv
// Top of the EEE transmit LPI controller: splits the timer word, qualifies
// link settle time, sequences transmit LPI and keeps sticky status.
// Assumes all inputs are synchronous to clk.
module lpi_tx_ctrl #(
    parameter int US_PER_MS = 1000,
    parameter int TW_W      = 16,
    parameter int LS_W      = 11,
    parameter int LS_LSB    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lpi_en,
    input  logic        auto_en,
    input  logic        link_ok,
    input  logic [31:0] cfg_timer,
    input  logic        txq_empty,
    input  logic        tick_us,
    input  logic        rx_lpi_enter,
    input  logic        rx_lpi_exit,
    input  logic        stat_rd,
    output logic        lpi_req,
    output logic        tx_hold,
    output logic [3:0]  stat,
    output logic        lpi_irq
);
    import lpi_pkg::*;

    logic [TW_W-1:0]   tw_us;
    logic [LS_W-1:0]   ls_ms;
    logic              ls_ok;
    logic              ev_enter, ev_exit;
    logic [N_STAT-1:0] ev;

    // Timer word fields
    always_comb begin
        tw_us = cfg_timer[TW_W-1:0];
        ls_ms = cfg_timer[LS_LSB +: LS_W];
    end

    // Gather status events in bit order
    always_comb begin
        ev              = '0;
        ev[ST_TX_ENTER] = ev_enter;
        ev[ST_TX_EXIT]  = ev_exit;
        ev[ST_RX_ENTER] = rx_lpi_enter;
        ev[ST_RX_EXIT]  = rx_lpi_exit;
    end

    lpi_ls_qual #(.LS_W(LS_W), .US_PER_MS(US_PER_MS)) u_ls (
        .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .tick(tick_us),
        .ls_ms(ls_ms), .ls_ok(ls_ok)
    );

    lpi_tx_fsm #(.TW_W(TW_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en), .auto_en(auto_en),
        .ls_ok(ls_ok), .txq_empty(txq_empty), .tick(tick_us), .tw_us(tw_us),
        .lpi_req(lpi_req), .tx_hold(tx_hold), .ev_enter(ev_enter), .ev_exit(ev_exit)
    );

    lpi_status #(.N(N_STAT)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev(ev), .rd(stat_rd),
        .stat(stat), .irq(lpi_irq)
    );

    // R9
    irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_irq == (stat != 4'd0));
endmodule

// File: tb/tb_lpi_tx_ctrl.sv
module tb_lpi_tx_ctrl;
    logic clk = 0, rst_n = 0;
    logic lpi_en = 0, auto_en = 0, link_ok = 0, txq_empty = 0, tick_us = 1;
    logic rx_lpi_enter = 0, rx_lpi_exit = 0, stat_rd = 0;
    logic [31:0] cfg_timer = 0;
    logic lpi_req, tx_hold, lpi_irq;
    logic [3:0] stat;
    int errs = 0, checks = 0;

    always #5 clk = ~clk;

    lpi_tx_ctrl dut (.*);

    // {rx_enter, rx_exit, rd, expected stat[3:0]}
    localparam logic [6:0] VEC [9] = '{
        7'b100_0100, 7'b000_0100, 7'b010_1100, 7'b001_0000,
        7'b101_0100, 7'b001_0000, 7'b010_1000, 7'b011_1000,
        7'b001_0000 };

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic read_clear();
        stat_rd = 1; step(); stat_rd = 0;
    endtask

    initial begin
        #1500000;
        errs++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 lpi_req", lpi_req, 0); chk("R1 tx_hold", tx_hold, 0);
        chk("R1 stat", stat, 0);       chk("R1 irq", lpi_irq, 0);
        rst_n = 1; step();

        // R7 R8 R9 status table, transmitter kept busy
        foreach (VEC[i]) begin
            {rx_lpi_enter, rx_lpi_exit, stat_rd} = VEC[i][6:4];
            step();
            {rx_lpi_enter, rx_lpi_exit, stat_rd} = 3'b000;
            chk("R7/R8 stat", stat, VEC[i][3:0]);
            chk("R9 irq", lpi_irq, |VEC[i][3:0]);
        end

        // R3 settle: LS=2 ms, TW=5 us
        cfg_timer = {5'd0, 11'd2, 16'd5};
        lpi_en = 1; auto_en = 1; txq_empty = 1;
        link_ok = 1;
        step(1500);
        // R4 link drop restarts timing
        link_ok = 0; step(); link_ok = 1;
        step(1999);
        chk("R4 no early entry", lpi_req, 0);
        step();
        chk("R3 settled no entry yet", lpi_req, 0);
        step();
        chk("R2/R3 lpi_req", lpi_req, 1);
        chk("R2 tx_hold", tx_hold, 1);
        chk("R7 tx enter bit", stat, 4'b0001);
        read_clear();

        // R5 exit by traffic, R6 TW=5
        txq_empty = 0; step();
        chk("R5 lpi_req fell", lpi_req, 0);
        chk("R5 hold kept", tx_hold, 1);
        chk("R7 tx exit bit", stat, 4'b0010);
        step(4);
        chk("R6 hold before TW", tx_hold, 1);
        step();
        chk("R6 hold released", tx_hold, 0);

        // R2 re-entry when queue empties; R5 exit by disable; R6 ticks gate wait
        txq_empty = 1; step();
        chk("R2 re-entry", lpi_req, 1);
        cfg_timer[15:0] = 16'd2;
        tick_us = 0;
        lpi_en = 0; step();
        chk("R5 exit on disable", lpi_req, 0);
        step(10);
        chk("R6 no tick no release", tx_hold, 1);
        tick_us = 1; step();
        chk("R6 one tick", tx_hold, 1);
        step();
        chk("R6 second tick releases", tx_hold, 0);

        // R6 TW=0
        cfg_timer[15:0] = 16'd0;
        lpi_en = 1; step();
        chk("R2 entry", lpi_req, 1);
        txq_empty = 0; step();
        chk("R6 TW0 hold", tx_hold, 1);
        step();
        chk("R6 TW0 release", tx_hold, 0);

        // R10 no entry without auto_en
        auto_en = 0; txq_empty = 1; step(20);
        chk("R10 no entry", lpi_req, 0);
        chk("R10 no hold", tx_hold, 0);

        // R1 reset clears active state
        auto_en = 1; step();
        rst_n = 0; step();
        chk("R1 reset lpi_req", lpi_req, 0);
        chk("R1 reset stat", stat, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule